// File: doc/BRIEF.md
# Serial Field Memory Write Port

This block is the write half of a serial field store that works as a programmable digital delay line. It runs on one write clock. Each cycle it samples an 8-bit data word and three controls: a pointer reset, a write enable that decides whether the pointer moves, and an input enable that decides whether the word is stored. The delay seen by a reader is set only by where the write reset lands in the stream. There is no load of an address.

The two qualifiers behave differently. With input enable off and write enable on, the pointer keeps moving but the array is left alone. A caller uses this to overlay a window of new data on an old field, for example picture-in-picture. With write enable off, the pointer freezes for as long as needed. A static polarity pin makes all three controls active-low. A static cascade pin delays both the controls and the data by one register, so that devices can be chained. Two pulse outputs flag a badly timed reset: one for a reset that follows the previous one too closely, and one for a field that stored too few words.

The storage is a parameterised register array inside the block. Its write port is driven by the registered address, data and strobe, and a combinational read port is brought out.

Top module: `fmw_write_port`

## Requirements
- R1: On a clock edge that samples the effective reset as active, the pointer becomes 0. The next stored word goes to address 0.
- R2: An edge whose effective reset is active stores nothing (wr_stb stays 0), whatever the levels of write enable and input enable.
- R3: A reset rising edge that comes after an earlier reset, with fewer than MIN_GAP (default 2) reset-inactive edges in between, raises gap_err for exactly one cycle after that edge.
- R4: When write enable and input enable are both active, wr_stb, wr_addr (the current pointer) and wr_data are registered at the sampling edge and the pointer increments. The array word at that address holds the data from the following edge.
- R5: When write enable is active and input enable is inactive, the pointer increments, wr_stb stays 0 and the array contents do not change.
- R6: When write enable is inactive and reset is inactive, the pointer holds and nothing is stored, whatever the input enable level, for any number of cycles.
- R7: When pol_low is 0, wrst, wen and ien are active at 1. When pol_low is 1, they are active at 0.
- R8: When cascade is 0, the controls and data act at the edge that samples them. When cascade is 1, both the controls and the data pass through one register, so every effect occurs one edge later.
- R9: A pointer at DEPTH-1 that increments wraps to 0.
- R10: A reset rising edge that is not the first since rst_n, and that comes when fewer than MIN_FIELD (default 140) words have been stored since the previous reset, raises short_err for exactly one cycle.
- R11: While rst_n is low and after it is released, the pointer is 0, the cascade register holds inactive controls, and wr_stb, gap_err and short_err are 0. The first reset after that is never flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| pol_low | input | 1 | Static control polarity select (1 = active-low) |
| cascade | input | 1 | Static cascade timing select (1 = one-cycle delayed access) |
| din | input | DATA_W | Serial input data |
| wrst | input | 1 | Write pointer reset |
| wen | input | 1 | Write enable (gates pointer advance) |
| ien | input | 1 | Input enable (gates the store only) |
| rd_addr | input | $clog2(DEPTH) | Array read address |
| rd_data | output | DATA_W | Array read data (combinational) |
| wr_addr | output | $clog2(DEPTH) | Registered array write address |
| wr_data | output | DATA_W | Registered array write data |
| wr_stb | output | 1 | Registered array write strobe |
| gap_err | output | 1 | One-cycle pulse: reset repeated too soon |
| short_err | output | 1 | One-cycle pulse: previous field too short |

## Verification
The hardest state to reach is a masked write into a location whose contents are already known. To test it, a complete field must first be stored, the pointer must then walk back over those addresses with input enable off, and the array must be read back afterwards. The stimulus first runs directed fields long enough to pass MIN_FIELD and to wrap the pointer. It then runs random enables with rare resets. A bench model tracks every stored word, and the array is swept at the end of each of the four polarity and cascade combinations. The error pulses are reached by directed resets with a gap of one and with a short field.

// File: rtl/fmw_pkg.sv
package fmw_pkg;

   // Control word after polarity normalisation: every bit active-high.
   typedef struct packed {
      logic rst;
      logic we;
      logic ie;
   } fmw_ctl_t;

   localparam fmw_ctl_t FMW_CTL_IDLE = '{rst: 1'b0, we: 1'b0, ie: 1'b0};

   function automatic fmw_ctl_t fmw_normalise(input logic low_sel,
                                              input logic r,
                                              input logic w,
                                              input logic i);
      fmw_ctl_t c;
      c.rst = r ^ low_sel;
      c.we  = w ^ low_sel;
      c.ie  = i ^ low_sel;
      return c;
   endfunction

endpackage

// File: rtl/fmw_in_stage.sv
module fmw_in_stage
   import fmw_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pol_low,
   input  logic              cascade,
   input  logic              wrst_i,
   input  logic              wen_i,
   input  logic              ien_i,
   input  logic [DATA_W-1:0] din_i,
   output fmw_ctl_t          ctl_o,
   output logic [DATA_W-1:0] data_o
);

   fmw_ctl_t          ctl_now;
   fmw_ctl_t          ctl_q;
   logic [DATA_W-1:0] data_q;

   always_comb ctl_now = fmw_normalise(pol_low, wrst_i, wen_i, ien_i);

   // Cascade stage: controls and data are held one edge together.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= FMW_CTL_IDLE;
         data_q <= '0;
      end else begin
         ctl_q  <= ctl_now;
         data_q <= din_i;
      end
   end

   always_comb begin
      ctl_o  = cascade ? ctl_q  : ctl_now;
      data_o = cascade ? data_q : din_i;
   end

   // R8: in cascade mode the effective control equals last edge's sample
   assert_cascade_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cascade && $past(rst_n)) |-> (ctl_o == $past(ctl_now)));

endmodule

// File: rtl/fmw_ptr.sv
module fmw_ptr
   import fmw_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 256,
   parameter int MIN_FIELD = 140,
   parameter int MIN_GAP   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  fmw_ctl_t                 ctl_i,
   input  logic [DATA_W-1:0]        data_i,
   output logic [$clog2(DEPTH)-1:0] wr_addr_o,
   output logic [DATA_W-1:0]        wr_data_o,
   output logic                     wr_stb_o,
   output logic                     gap_err_o,
   output logic                     short_err_o
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(MIN_FIELD + 1);
   localparam int GW = $clog2(MIN_GAP + 1);
   localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
   localparam logic [CW-1:0] FIELD_SAT = CW'(MIN_FIELD);
   localparam logic [GW-1:0] GAP_SAT   = GW'(MIN_GAP);

   logic [AW-1:0] ptr_q;
   logic [CW-1:0] stored_q;
   logic [GW-1:0] idle_q;
   logic          prev_rst_q;
   logic          seen_rst_q;
   logic          store;
   logic          rst_rise;

   always_comb begin
      store    = ctl_i.we && ctl_i.ie && !ctl_i.rst;
      rst_rise = ctl_i.rst && !prev_rst_q;
   end

   // Pointer: reset wins, enable advances, otherwise hold.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (ctl_i.rst) begin
         ptr_q <= '0;
      end else if (ctl_i.we) begin
         ptr_q <= (ptr_q == LAST_ADDR) ? '0 : ptr_q + 1'b1;
      end
   end

   // Registered write port toward the array.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_stb_o  <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         wr_stb_o  <= store;
         wr_addr_o <= ptr_q;
         wr_data_o <= data_i;
      end
   end

   // Reset protocol tracking.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stored_q    <= '0;
         idle_q      <= '0;
         prev_rst_q  <= 1'b0;
         seen_rst_q  <= 1'b0;
         gap_err_o   <= 1'b0;
         short_err_o <= 1'b0;
      end else begin
         prev_rst_q  <= ctl_i.rst;
         gap_err_o   <= rst_rise && seen_rst_q && (idle_q < GAP_SAT);
         short_err_o <= rst_rise && seen_rst_q && (stored_q < FIELD_SAT);
         if (ctl_i.rst) begin
            stored_q   <= '0;
            idle_q     <= '0;
            seen_rst_q <= 1'b1;
         end else begin
            if (idle_q < GAP_SAT)                stored_q <= stored_q;
            if (idle_q < GAP_SAT)                idle_q   <= idle_q + 1'b1;
            if (store && stored_q < FIELD_SAT)   stored_q <= stored_q + 1'b1;
         end
      end
   end

   // R1: a reset edge leaves the pointer at zero
   assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_i.rst |=> (ptr_q == '0));

   // R2: nothing is stored from a reset edge
   assert_reset_no_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_i.rst |=> !wr_stb_o);

   // R3: gap error is a single-cycle pulse
   assert_gap_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      gap_err_o |=> !gap_err_o);

   // R6: disabled write holds the pointer
   assert_hold_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_i.rst && !ctl_i.we) |=> $stable(ptr_q));

   // R9: wrap from the last address
   assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_i.rst && ctl_i.we && ptr_q == LAST_ADDR) |=> (ptr_q == '0));

   // R10: short field error is a single-cycle pulse
   assert_short_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      short_err_o |=> !short_err_o);

endmodule

// File: rtl/fmw_array.sv
module fmw_array #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 256
) (
   input  logic                     clk,
   input  logic                     we_i,
   input  logic [$clog2(DEPTH)-1:0] waddr_i,
   input  logic [DATA_W-1:0]        wdata_i,
   input  logic [$clog2(DEPTH)-1:0] raddr_i,
   output logic [DATA_W-1:0]        rdata_o
);

   localparam int AW = $clog2(DEPTH);

   logic [DATA_W-1:0] word_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (we_i && waddr_i == AW'(g)) word_q[g] <= wdata_i;
      end
   end

   always_comb rdata_o = word_q[raddr_i];

endmodule

// File: rtl/fmw_write_port.sv
module fmw_write_port
   import fmw_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 256,
   parameter int MIN_FIELD = 140,
   parameter int MIN_GAP   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pol_low,
   input  logic                     cascade,
   input  logic [DATA_W-1:0]        din,
   input  logic                     wrst,
   input  logic                     wen,
   input  logic                     ien,
   input  logic [$clog2(DEPTH)-1:0] rd_addr,
   output logic [DATA_W-1:0]        rd_data,
   output logic [$clog2(DEPTH)-1:0] wr_addr,
   output logic [DATA_W-1:0]        wr_data,
   output logic                     wr_stb,
   output logic                     gap_err,
   output logic                     short_err
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fmw_write_port: DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("fmw_write_port: DATA_W must be positive");
   end
   if (MIN_FIELD < 1 || MIN_GAP < 1) begin : g_bad_limits
      $error("fmw_write_port: MIN_FIELD and MIN_GAP must be positive");
   end

   fmw_ctl_t          ctl_eff;
   logic [DATA_W-1:0] data_eff;

   fmw_in_stage #(.DATA_W(DATA_W)) u_in (
      .clk     (clk),
      .rst_n   (rst_n),
      .pol_low (pol_low),
      .cascade (cascade),
      .wrst_i  (wrst),
      .wen_i   (wen),
      .ien_i   (ien),
      .din_i   (din),
      .ctl_o   (ctl_eff),
      .data_o  (data_eff)
   );

   fmw_ptr #(
      .DATA_W    (DATA_W),
      .DEPTH     (DEPTH),
      .MIN_FIELD (MIN_FIELD),
      .MIN_GAP   (MIN_GAP)
   ) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_i       (ctl_eff),
      .data_i      (data_eff),
      .wr_addr_o   (wr_addr),
      .wr_data_o   (wr_data),
      .wr_stb_o    (wr_stb),
      .gap_err_o   (gap_err),
      .short_err_o (short_err)
   );

   fmw_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
      .clk     (clk),
      .we_i    (wr_stb),
      .waddr_i (wr_addr),
      .wdata_i (wr_data),
      .raddr_i (rd_addr),
      .rdata_o (rd_data)
   );

   // R11: outputs quiet in the first cycle after chip reset release
   assert_reset_quiet_R11: assert property (@(posedge clk)
      !rst_n |=> (!wr_stb && !gap_err && !short_err));

endmodule

// File: tb/fmw_write_port_tb.sv
`timescale 1ns/1ps
module fmw_write_port_tb;

   localparam int DW    = 8;
   localparam int DEPTH = 256;
   localparam int MINF  = 140;
   localparam int MING  = 2;
   localparam int AW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pol_low = 1'b0;
   logic          cascade = 1'b0;
   logic [DW-1:0] din = '0;
   logic          wrst = 1'b0, wen = 1'b0, ien = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic          wr_stb, gap_err, short_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   fmw_write_port #(.DATA_W(DW), .DEPTH(DEPTH), .MIN_FIELD(MINF), .MIN_GAP(MING)) u_dut (
      .clk(clk), .rst_n(rst_n), .pol_low(pol_low), .cascade(cascade), .din(din),
      .wrst(wrst), .wen(wen), .ien(ien), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_stb(wr_stb),
      .gap_err(gap_err), .short_err(short_err));

   // Reference model state (logical, active-high controls)
   bit          p_r, p_w, p_i;
   logic [DW-1:0] p_d;
   int          m_ptr, m_idle, m_stored;
   bit          m_seen, m_prev_r;
   logic [DW-1:0] m_mem [DEPTH];
   bit          m_val [DEPTH];
   bit          e_stb, e_gap, e_short;
   int          e_addr;
   logic [DW-1:0] e_data;
   string       e_tag;

   function automatic int next_ptr(int p);
      return (p == DEPTH - 1) ? 0 : p + 1;   // R9 wrap
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s (R7 pol=%0d R8 cas=%0d) actual=%0h expected=%0h t=%0t",
                  tag, pol_low, cascade, act, exp_v, $time);
      end
   endtask

   task automatic model_edge(bit r, bit w, bit i, logic [DW-1:0] d);
      bit er, ew, ei;
      logic [DW-1:0] ed;
      if (cascade) begin er = p_r; ew = p_w; ei = p_i; ed = p_d; end   // R8
      else begin er = r; ew = w; ei = i; ed = d; end
      p_r = r; p_w = w; p_i = i; p_d = d;
      e_stb  = ew && ei && !er;
      e_addr = m_ptr;
      e_data = ed;
      e_tag  = er ? "R2" : (!ew ? "R6" : (!ei ? "R5" : "R4"));
      e_gap   = er && !m_prev_r && m_seen && (m_idle < MING);
      e_short = er && !m_prev_r && m_seen && (m_stored < MINF);
      if (e_stb) begin m_mem[m_ptr] = ed; m_val[m_ptr] = 1; end
      if (er) begin
         m_ptr = 0; m_idle = 0; m_stored = 0; m_seen = 1;
      end else begin
         if (m_idle < MING) m_idle++;
         if (ew) m_ptr = next_ptr(m_ptr);
         if (ew && ei && m_stored < MINF) m_stored++;
      end
      m_prev_r = er;
   endtask

   task automatic cyc(bit r, bit w, bit i, logic [DW-1:0] d);
      wrst = r ^ pol_low; wen = w ^ pol_low; ien = i ^ pol_low;   // R7
      din  = d;
      model_edge(r, w, i, d);
      @(posedge clk);
      @(negedge clk);
      chk(wr_stb == e_stb, e_tag, wr_stb, e_stb);
      if (e_stb) begin
         chk(wr_addr == AW'(e_addr), (e_addr == 0) ? "R1 R9" : "R4", wr_addr, e_addr);
         chk(wr_data == e_data, "R4", wr_data, e_data);
      end
      chk(gap_err == e_gap, "R3", gap_err, e_gap);
      chk(short_err == e_short, "R10", short_err, e_short);
   endtask

   task automatic chip_reset(bit pol, bit cas);
      @(negedge clk);
      rst_n = 0; pol_low = pol; cascade = cas;
      wrst = pol; wen = pol; ien = pol;
      repeat (3) @(negedge clk);
      chk(!wr_stb && !gap_err && !short_err, "R11", {wr_stb, gap_err, short_err}, 0);
      rst_n = 1;
      p_r = 0; p_w = 0; p_i = 0; p_d = '0;
      m_ptr = 0; m_idle = 0; m_stored = 0; m_seen = 0; m_prev_r = 0;
      for (int k = 0; k < DEPTH; k++) m_val[k] = 0;
   endtask

   task automatic sweep();
      repeat (3) cyc(0, 0, 0, 8'h00);
      for (int a = 0; a < DEPTH; a++) begin
         if (m_val[a]) begin
            rd_addr = AW'(a);
            #1;
            chk(rd_data == m_mem[a], "R5", rd_data, m_mem[a]);
         end
      end
   endtask

   task automatic run_config(bit pol, bit cas);
      chip_reset(pol, cas);
      // R11: pointer 0 before any reset
      cyc(0, 1, 1, 8'h5a);
      // R2: reset with both enables active stores nothing
      cyc(1, 1, 1, 8'hee);
      cyc(0, 0, 0, 8'h00);
      cyc(0, 0, 0, 8'h00);
      for (int k = 0; k < 20; k++) cyc(0, 1, 1, DW'($urandom));   // R4
      for (int k = 0; k < 4; k++)  cyc(0, 0, 1, DW'($urandom));   // R6
      for (int k = 0; k < 5; k++)  cyc(0, 1, 0, DW'($urandom));   // R5
      for (int k = 0; k < 3; k++)  cyc(0, 1, 1, DW'($urandom));
      // R3 and R10: reset repeated after a single idle edge
      cyc(1, 0, 0, 8'h00);
      cyc(0, 0, 0, 8'h00);
      cyc(1, 0, 0, 8'h00);
      cyc(0, 0, 0, 8'h00);
      cyc(0, 0, 0, 8'h00);
      // full field then reset: no error
      for (int k = 0; k < MINF + 10; k++) cyc(0, 1, 1, DW'($urandom));
      cyc(1, 1, 0, 8'h00);
      cyc(1, 0, 0, 8'h00);
      // masked overlay over the earlier field (R5)
      for (int k = 0; k < 30; k++) cyc(0, 1, (k % 3) == 0, DW'($urandom));
      cyc(0, 0, 0, 8'h00);
      cyc(0, 0, 0, 8'h00);
      cyc(1, 0, 0, 8'h00);   // R10: field only 10 words
      // R9: long run through the wrap
      for (int k = 0; k < DEPTH + 40; k++) cyc(0, 1, 1, DW'($urandom));
      // constrained random
      for (int k = 0; k < 400; k++) begin
         bit r;
         r = ($urandom % 40) == 0;
         cyc(r, ($urandom % 4) != 0, ($urandom % 4) != 0, DW'($urandom));
      end
      sweep();
   endtask

   initial begin
      int seed_unused;
      seed_unused = $urandom(32'h1b2c3d);
      run_config(0, 0);
      run_config(1, 0);
      run_config(0, 1);
      run_config(1, 1);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule